// File: doc/BRIEF.md
# Touchscreen ADC Byte Responder

This block models the converter that answers a host's serial byte exchanges on behalf of a touch panel controller. After each completed byte transfer it decides which byte the host will shift out on the next exchange. A received byte with its top bit set is a command: it picks one of eight analog channels and arms a two-byte readout of a 12-bit conversion result. The upper seven result bits come first, in the low seven bits of a byte. The lower five result bits come next, left-justified. Zeros follow until a new command arrives.

Channel values come from per-channel sample inputs. Selected channels can instead be tied to a fixed level by parameter, and by default the Y-position channel reads full scale. The host's control-register writes are presented as a strobe with the chip-select-hold level. A write that drops the hold discards the armed command. Pen-interrupt signalling and real conversion are not part of the block.

Top module: `tsc_byte_responder`

## Requirements
- R1: After reset `txByte` is 0x00 and no command is held, so the first non-command transfer returns 0x00.
- R2: A transfer (`xferDone` high for one cycle) whose `rxByte` has bit 7 set is latched as a command, with the channel code in bits 6..4. The command takes effect for the following transfer.
- R3: The first transfer after a command sets `txByte` to {1'b0, result[11:5]}. The result is sampled in that cycle.
- R4: The second transfer after a command sets `txByte` to {result[4:0], 3'b000}.
- R5: Every further transfer returns 0x00 until another command is latched.
- R6: With no command held, each transfer returns 0x00.
- R7: Channel codes: 0 temperature A, 1 Y position, 2 battery, 3 pressure A, 4 pressure B, 5 X position, 6 microphone, 7 temperature B. Channel k reads `chanSample[12k+11:12k]`, except that the Y-position channel reads the fixed level 0xFFF and ignores its sample input.
- R8: A change of the selected sample input after the first result byte does not alter the second result byte.
- R9: A command arriving on the same transfer that returns a result byte still returns that byte. It then restarts the sequence, so the next transfer returns the upper part for the new channel.
- R10: `holdWrite` with `holdLevel` low clears the held command and the sequence, so the next non-command transfer returns 0x00. With `holdLevel` high the write has no effect. A command byte on the same cycle as a clearing write is still latched.
- R11: `txByte` changes only in the cycle after `xferDone`. `rxByte` is ignored while `xferDone` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxByte | input | 8 | Byte received from the host on the completed transfer |
| xferDone | input | 1 | One-cycle strobe marking a completed byte transfer |
| holdWrite | input | 1 | One-cycle strobe for a host control-register write |
| holdLevel | input | 1 | Chip-select-hold bit carried by that write |
| chanSample | input | 96 | Eight 12-bit channel samples, channel k at bits 12k+11..12k |
| txByte | output | 8 | Byte to return on the next transfer |

## Verification
Command latching and result serialization share the transfer strobe, so a command byte can land on the very transfer that emits an upper or lower result byte. The vector walk places command bytes on both kinds of transfer. Each time it expects the old sequence's byte on that transfer and the new channel's upper part on the next. A second collision, a clearing control write in the same cycle as a command transfer, is driven directly. It is judged by the pending upper part still appearing and the new command surviving the clear.

// File: rtl/tsc_resp_pkg.sv
package tsc_resp_pkg;

  typedef enum logic [2:0] {
    CH_TEMP_A  = 3'd0,
    CH_YPOS    = 3'd1,
    CH_BATTERY = 3'd2,
    CH_PRESS_A = 3'd3,
    CH_PRESS_B = 3'd4,
    CH_XPOS    = 3'd5,
    CH_MIC     = 3'd6,
    CH_TEMP_B  = 3'd7
  } chan_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_UPPER = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;

  typedef struct packed {
    logic  sendUpper;
    logic  sendLower;
    logic  sendZero;
    chan_e chanSel;
  } resp_strobe_t;

endpackage

// File: rtl/tsc_resp_ctrl.sv
module tsc_resp_ctrl
  import tsc_resp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   rxByte,
  input  logic         xferDone,
  input  logic         holdWrite,
  input  logic         holdLevel,
  output resp_strobe_t strobe
);

  logic [7:0] cmdByte;
  phase_e     phase;
  logic       cmdHeld;
  logic       cmdIn;
  logic       dropHold;

  assign cmdHeld  = cmdByte[7];
  assign cmdIn    = xferDone && rxByte[7];
  assign dropHold = holdWrite && !holdLevel;

  always_comb begin
    strobe.sendUpper = 1'b0;
    strobe.sendLower = 1'b0;
    strobe.sendZero  = 1'b0;
    strobe.chanSel   = chan_e'(cmdByte[6:4]);
    if (xferDone) begin
      unique case (phase)
        PH_IDLE:  begin
          if (cmdHeld) strobe.sendUpper = 1'b1;
          else         strobe.sendZero  = 1'b1;
        end
        PH_UPPER: strobe.sendLower = 1'b1;
        default:  strobe.sendZero  = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdByte <= 8'h00;
      phase   <= PH_IDLE;
    end else begin
      if (strobe.sendUpper) phase <= PH_UPPER;
      if (strobe.sendLower) phase <= PH_DONE;
      if (dropHold) begin
        cmdByte <= 8'h00;
        phase   <= PH_IDLE;
      end
      if (cmdIn) begin
        cmdByte <= rxByte;
        phase   <= PH_IDLE;
      end
    end
  end

  AST_CMD_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    cmdIn |=> (cmdByte == $past(rxByte))); // R2

  AST_CMD_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    cmdIn |=> (phase == PH_IDLE)); // R9

  AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (dropHold && !cmdIn) |=> (cmdByte == 8'h00 && phase == PH_IDLE)); // R10

  AST_NO_XFER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!xferDone && !holdWrite) |=> ($stable(cmdByte) && $stable(phase))); // R11

endmodule

// File: rtl/tsc_resp_datapath.sv
module tsc_resp_datapath
  import tsc_resp_pkg::*;
#(
  parameter int          NUM_CH      = 8,
  parameter int          RES         = 12,
  parameter logic [7:0]  FIXED_MASK  = 8'b0000_0010,
  parameter logic [11:0] FIXED_LEVEL = 12'hFFF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  resp_strobe_t          strobe,
  input  logic [NUM_CH*RES-1:0] chanSample,
  output logic [7:0]            txByte
);

  localparam int UPPER_W = 7;
  localparam int LOWER_W = RES - UPPER_W;
  localparam int PAD_W   = 8 - LOWER_W;

  logic [RES-1:0]     chanLevel [NUM_CH];
  logic [RES-1:0]     selLevel;
  logic [LOWER_W-1:0] heldLower;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    if (FIXED_MASK[k]) begin : g_fixed
      assign chanLevel[k] = FIXED_LEVEL[RES-1:0];
    end else begin : g_live
      assign chanLevel[k] = chanSample[k*RES +: RES];
    end
  end

  assign selLevel = chanLevel[strobe.chanSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txByte    <= 8'h00;
      heldLower <= '0;
    end else if (strobe.sendUpper) begin
      txByte    <= {1'b0, selLevel[RES-1 -: UPPER_W]};
      heldLower <= selLevel[LOWER_W-1:0];
    end else if (strobe.sendLower) begin
      txByte    <= {heldLower, {PAD_W{1'b0}}};
    end else if (strobe.sendZero) begin
      txByte    <= 8'h00;
    end
  end

  AST_UPPER_MSB: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendUpper |=> !txByte[7]); // R3

  AST_LOWER_PAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendLower |=> (txByte[PAD_W-1:0] == '0)); // R4

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendZero |=> (txByte == 8'h00)); // R5

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.sendUpper, strobe.sendLower, strobe.sendZero})); // R11

endmodule

// File: rtl/tsc_byte_responder.sv
module tsc_byte_responder
  import tsc_resp_pkg::*;
#(
  parameter int          NUM_CH      = 8,
  parameter int          RES         = 12,
  parameter logic [7:0]  FIXED_MASK  = 8'b0000_0010,
  parameter logic [11:0] FIXED_LEVEL = 12'hFFF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [7:0]            rxByte,
  input  logic                  xferDone,
  input  logic                  holdWrite,
  input  logic                  holdLevel,
  input  logic [NUM_CH*RES-1:0] chanSample,
  output logic [7:0]            txByte
);

  resp_strobe_t strobe;

  tsc_resp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxByte    (rxByte),
    .xferDone  (xferDone),
    .holdWrite (holdWrite),
    .holdLevel (holdLevel),
    .strobe    (strobe)
  );

  tsc_resp_datapath #(
    .NUM_CH      (NUM_CH),
    .RES         (RES),
    .FIXED_MASK  (FIXED_MASK),
    .FIXED_LEVEL (FIXED_LEVEL)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .chanSample (chanSample),
    .txByte     (txByte)
  );

  AST_TX_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !xferDone |=> $stable(txByte)); // R11

endmodule

// File: tb/tsc_byte_responder_test.sv
module tsc_byte_responder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  rxByte = 8'h00;
  logic        xferDone = 1'b0;
  logic        holdWrite = 1'b0;
  logic        holdLevel = 1'b1;
  logic [95:0] chanSample;
  logic [7:0]  txByte;

  int applied = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tsc_byte_responder uut (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .xferDone(xferDone),
    .holdWrite(holdWrite), .holdLevel(holdLevel),
    .chanSample(chanSample), .txByte(txByte)
  );

  // {rxByte, expected txByte, requirement id}
  localparam logic [19:0] VEC [21] = '{
    {8'h00, 8'h00, 4'd6}, {8'h85, 8'h00, 4'd6}, {8'h00, 8'h09, 4'd3},
    {8'h00, 8'h18, 4'd4}, {8'h00, 8'h00, 4'd5}, {8'h00, 8'h00, 4'd5},
    {8'h90, 8'h00, 4'd5}, {8'h00, 8'h7F, 4'd7}, {8'h00, 8'hF8, 4'd7},
    {8'hD3, 8'h00, 4'd5}, {8'h00, 8'h55, 4'd7}, {8'hA0, 8'hE0, 4'd9},
    {8'h00, 8'h4F, 4'd9}, {8'hB0, 8'h80, 4'd9}, {8'h7F, 8'h02, 4'd9},
    {8'h00, 8'hA8, 4'd7}, {8'hC0, 8'h00, 4'd5}, {8'hE0, 8'h7F, 4'd9},
    {8'hF0, 8'h3E, 4'd9}, {8'h00, 8'h40, 4'd7}, {8'h00, 8'h00, 4'd5}
  };

  function automatic string reqName(input logic [3:0] id);
    case (id)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    applied++;
    if (txByte !== exp) begin
      fails++;
      $display("FAIL %s: txByte=%02h expected %02h", req, txByte, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b);
    @(negedge clk);
    rxByte = b;
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
  endtask

  task automatic ctrlWrite(input logic lvl);
    @(negedge clk);
    holdWrite = 1'b1;
    holdLevel = lvl;
    @(negedge clk);
    holdWrite = 1'b0;
    holdLevel = 1'b1;
  endtask

  task automatic setSample(input int ch, input logic [11:0] v);
    chanSample[ch*12 +: 12] = v;
  endtask

  task automatic loadSamples();
    setSample(0, 12'h123); setSample(1, 12'h000); setSample(2, 12'h9F0);
    setSample(3, 12'h055); setSample(4, 12'hFEE); setSample(5, 12'hABC);
    setSample(6, 12'h7C1); setSample(7, 12'h800);
  endtask

  initial begin
    loadSamples();
    repeat (3) @(negedge clk);
    check("R1", 8'h00);
    rstN = 1'b1;

    for (int i = 0; i < 21; i++) begin
      xfer(VEC[i][19:12]);
      check(reqName(VEC[i][3:0]), VEC[i][11:4]);
    end

    // R8: sample change after the upper byte does not reach the lower byte
    xfer(8'hD0); check("R8", 8'h00);
    xfer(8'h00); check("R8", 8'h55);
    setSample(5, 12'h000);
    repeat (4) @(negedge clk);
    check("R11", 8'h55);
    xfer(8'h00); check("R8", 8'hE0);
    setSample(5, 12'hABC);

    // R11: a command on rxByte without the strobe is ignored
    @(negedge clk); rxByte = 8'h90;
    repeat (3) @(negedge clk);
    check("R11", 8'hE0);
    xfer(8'h00); check("R11", 8'h00);

    // R10: write with hold high keeps the command
    xfer(8'hD0); check("R10", 8'h00);
    ctrlWrite(1'b1);
    xfer(8'h00); check("R10", 8'h55);
    // R10: write with hold low discards the rest of the sequence
    ctrlWrite(1'b0);
    xfer(8'h00); check("R10", 8'h00);
    xfer(8'h00); check("R10", 8'h00);

    // R10: clear before use, then a new command still works
    xfer(8'hD0); check("R10", 8'h00);
    ctrlWrite(1'b0);
    xfer(8'h00); check("R10", 8'h00);
    xfer(8'h90); check("R2", 8'h00);
    xfer(8'h00); check("R2", 8'h7F);

    // R10/R9: clearing write and command transfer in the same cycle
    xfer(8'hD0); check("R10", 8'hF8);
    @(negedge clk);
    rxByte = 8'h90; xferDone = 1'b1; holdWrite = 1'b1; holdLevel = 1'b0;
    @(negedge clk);
    xferDone = 1'b0; holdWrite = 1'b0; holdLevel = 1'b1;
    check("R10", 8'h55);
    xfer(8'h00); check("R10", 8'h7F);

    // R7: Y sample input is ignored
    setSample(1, 12'h3A5);
    xfer(8'h9C); check("R7", 8'hF8);
    xfer(8'h00); check("R7", 8'h7F);

    // R1: reset in mid-sequence
    xfer(8'hD0); check("R1", 8'hF8);
    xfer(8'h00); check("R1", 8'h55);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); check("R1", 8'h00);
    rstN = 1'b1;
    xfer(8'h00); check("R1", 8'h00);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run incomplete, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule